// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Edge Resynchronisation

This block turns an oversampled CAN receive line into a stream of sampled bits. The line arrives already synchronised to the system clock. While idle, the block waits for a dominant (low) level. Once it has one, it places a sample instant inside every bit time. Each sampled bit is presented with a one-cycle strobe and its index within the frame. The index counts stuff bits as well, so a downstream frame parser can destuff and decode.

Sample instants are measured from a moving anchor, not from a free-running bit counter. The anchor is the most recent recessive-to-dominant transition on the line, or the tick at which the parser switches to the fast data-phase rate. Bit periods are given in clock ticks with eight fractional bits, so rates that do not divide the clock evenly do not drift. The sample point is a percentage of the active period. A rate-select input chooses between the nominal period and the fast period. A frame-end input returns the block to idle.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset, `bitStrobe`, `bitCount` and `active` are all 0.
- R2: While idle, a recessive (1) line produces no strobe and `active` stays 0. The first tick that sees a low level starts collection: `active` becomes 1, and that tick becomes the anchor for bit index 0. A level is enough; no edge is required.
- R3: Bit n is sampled at the first tick whose distance from the anchor is at least floor(P·(n − k) + O). Here k is the bit index paired with the anchor, P is the active period in Q8 ticks, and O = floor(P·samplePct/100) in Q8.
- R4: One cycle after the sampling tick, `bitStrobe` is high for exactly one cycle. In that cycle `bitValue` holds the line level seen at the sampling tick and `bitCount` holds that bit's index.
- R5: During collection, a falling edge (line 1 then 0 on consecutive ticks) makes its tick the new anchor, paired with the index of the next bit not yet sampled.
- R6: If a falling edge lands on the tick where a sample is due, the bit is taken with the low level. The next bit is then sampled P + O ticks after that tick.
- R7: Periods and offsets carry 8 fractional bits. Sample positions accumulate in Q8, so a period of 50.5 ticks keeps its fractional phase over successive bits.
- R8: `bitCount` advances by one for every strobed bit, stuff bits included, starting at 0 for the first bit of a frame.
- R9: A rising `rateFast` seen during collection re-anchors at that tick. The next sample lands floor(Pf + Of) ticks later, and following bits are spaced by the fast period Pf.
- R10: A falling `rateFast` does not re-anchor and does not move the pending sample. Bits after that pending one are spaced by the nominal period.
- R11: A `frameEnd` pulse returns the block to idle in the next cycle, with `active` 0 and `bitCount` 0. It also forces the nominal period, which stays in force even if `rateFast` is still high. Only a new rising edge of `rateFast` selects the fast period again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick of bit timing |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Synchronised bus level, 0 = dominant |
| nomPeriod | input | 20 | Nominal bit period in ticks, Q12.8 |
| fastPeriod | input | 20 | Fast data-phase bit period in ticks, Q12.8 |
| samplePct | input | 7 | Sample point as a percentage of the period (0..100) |
| rateFast | input | 1 | Rate select from the frame parser, 1 = fast |
| frameEnd | input | 1 | Pulse that ends the frame and returns to idle |
| bitStrobe | output | 1 | One-cycle strobe for each sampled bit |
| bitValue | output | 1 | Level of the sampled bit |
| bitCount | output | 10 | Index of the strobed bit within the frame |
| active | output | 1 | High while bits are being collected |

## Verification
The main function is driven with several line patterns, and each separates one behaviour from its neighbours.
- Bits of exact nominal length confirm the basic sample positions.
- A stretched recessive bit followed by a late falling edge can only match the expected tick if the anchor moved to that edge.
- A falling edge placed exactly on a due sample separates the coincident rule from plain re-anchoring. The two rules put the following bit at different ticks.
- A 50.5-tick period with no further edges exposes any loss of the fraction, because integer accumulation drifts by one tick every two bits.
- A rate raise and a later lower, each placed between samples, distinguish re-anchoring from not re-anchoring.
- A frame end with the rate select held high shows that the nominal spacing returns.

// File: rtl/canbs_pkg.sv
package canbs_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } rxState_t;

  // Per-tick commands from control to datapath
  typedef struct packed {
    logic start;       // first dominant level seen while idle
    logic clear;       // frame end: back to idle
    logic take;        // sample the line this tick
    logic edgeAnchor;  // falling edge: new anchor
    logic rateUp;      // switch to fast period, re-anchor
    logic rateDown;    // switch back to nominal period
  } ctrlStrobes_t;

endpackage

// File: rtl/canbs_offset.sv
// Sample offset = period * percent / 100, kept in the period's fixed-point format.
module canbs_offset #(
  parameter int PER_W = 20,
  parameter int PCT_W = 7
) (
  input  logic [PER_W-1:0] periodQ,
  input  logic [PCT_W-1:0] pct,
  output logic [PER_W-1:0] offsetQ
);
  localparam int PROD_W = PER_W + PCT_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    prod    = PROD_W'(periodQ) * PROD_W'(pct);
    quot    = prod / PROD_W'(100);
    offsetQ = quot[PER_W-1:0];
  end
endmodule

// File: rtl/canbs_ctrl.sv
module canbs_ctrl
  import canbs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxLine,
  input  logic         rateFast,
  input  logic         frameEnd,
  input  logic         sampleDue,
  output ctrlStrobes_t st,
  output logic         collecting
);
  rxState_t state;
  logic     prevRx;
  logic     prevRate;

  assign collecting = (state == ST_COLLECT);

  always_comb begin
    st = '0;
    st.clear = frameEnd;
    if (!frameEnd) begin
      if (state == ST_IDLE) begin
        st.start = !rxLine;
      end else begin
        st.take       = sampleDue;
        st.rateUp     = rateFast && !prevRate;
        st.rateDown   = !rateFast && prevRate;
        st.edgeAnchor = !rxLine && prevRx && !st.rateUp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      prevRx   <= 1'b1;
      prevRate <= 1'b0;
    end else begin
      prevRx   <= rxLine;
      prevRate <= rateFast;
      if (st.clear)      state <= ST_IDLE;
      else if (st.start) state <= ST_COLLECT;
    end
  end

  // R11: a frame end always lands in idle
  assert_clear_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !collecting);

  // R2: a low level in idle (without frame end) starts collection
  assert_level_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!collecting && !rxLine && !frameEnd) |=> collecting);

endmodule

// File: rtl/canbs_datapath.sv
module canbs_datapath
  import canbs_pkg::*;
#(
  parameter int PER_W  = 20,
  parameter int FRAC_W = 8,
  parameter int TICK_W = 24,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              collecting,
  input  ctrlStrobes_t      st,
  input  logic [PER_W-1:0]  nomPeriod,
  input  logic [PER_W-1:0]  fastPeriod,
  input  logic [PER_W-1:0]  nomOffset,
  input  logic [PER_W-1:0]  fastOffset,
  output logic              sampleDue,
  output logic              bitStrobe,
  output logic              bitValue,
  output logic [CNT_W-1:0]  bitCount
);
  localparam int NQ_W = TICK_W + FRAC_W;

  logic [TICK_W-1:0] elapsed;     // whole ticks since the anchor
  logic [NQ_W-1:0]   nextQ;       // next sample position from the anchor, Q8
  logic [CNT_W-1:0]  curBit;      // index of the next bit to sample
  logic              fastMode;

  logic [NQ_W-1:0]   perSel;
  logic [NQ_W-1:0]   offSel;
  logic [NQ_W:0]     advSum;
  logic [NQ_W-1:0]   perNext;
  logic [TICK_W-1:0] elapsedInc;

  always_comb begin
    perSel     = fastMode ? NQ_W'(fastPeriod) : NQ_W'(nomPeriod);
    offSel     = fastMode ? NQ_W'(fastOffset) : NQ_W'(nomOffset);
    advSum     = {1'b0, nextQ} + {1'b0, perSel};
    perNext    = advSum[NQ_W] ? '1 : advSum[NQ_W-1:0];
    elapsedInc = (elapsed == '1) ? elapsed : elapsed + 1'b1;
  end

  assign sampleDue = collecting && (elapsed >= nextQ[NQ_W-1:FRAC_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed   <= '0;
      nextQ     <= '0;
      curBit    <= '0;
      fastMode  <= 1'b0;
      bitStrobe <= 1'b0;
      bitValue  <= 1'b1;
      bitCount  <= '0;
    end else if (st.clear) begin
      elapsed   <= '0;
      nextQ     <= '0;
      curBit    <= '0;
      fastMode  <= 1'b0;
      bitStrobe <= 1'b0;
      bitCount  <= '0;
    end else begin
      bitStrobe <= st.take;
      if (st.take) begin
        bitValue <= rxLine;
        bitCount <= curBit;
        curBit   <= curBit + 1'b1;
      end

      if (st.start) begin
        elapsed  <= TICK_W'(1);
        nextQ    <= NQ_W'(nomOffset);
        curBit   <= '0;
        fastMode <= 1'b0;
      end else if (st.rateUp) begin
        elapsed  <= TICK_W'(1);
        nextQ    <= NQ_W'(fastPeriod) + NQ_W'(fastOffset);
        fastMode <= 1'b1;
      end else if (st.edgeAnchor) begin
        elapsed <= TICK_W'(1);
        nextQ   <= st.take ? (perSel + offSel) : offSel;
      end else if (st.take) begin
        elapsed <= elapsedInc;
        nextQ   <= perNext;
      end else if (collecting) begin
        elapsed <= elapsedInc;
      end

      if (st.rateDown) fastMode <= 1'b0;
    end
  end

  // R2: nothing is strobed out of idle
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !collecting |=> !bitStrobe);

  // R8: the reported index always trails the next index by one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curBit != '0) |-> (bitCount == curBit - 1'b1));

  // R3: two samples are never on adjacent ticks (periods are at least 2 ticks)
  assert_sample_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.take |=> !sampleDue);

  // R11: frame end leaves no strobe, a zero index and the nominal period
  assert_clear_state_R11: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> (!bitStrobe && bitCount == '0 && !fastMode));

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import canbs_pkg::*;
#(
  parameter int PER_W  = 20,
  parameter int FRAC_W = 8,
  parameter int PCT_W  = 7,
  parameter int TICK_W = 24,
  parameter int CNT_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [PER_W-1:0] nomPeriod,
  input  logic [PER_W-1:0] fastPeriod,
  input  logic [PCT_W-1:0] samplePct,
  input  logic             rateFast,
  input  logic             frameEnd,
  output logic             bitStrobe,
  output logic             bitValue,
  output logic [CNT_W-1:0] bitCount,
  output logic             active
);
  ctrlStrobes_t     st;
  logic             sampleDue;
  logic [PER_W-1:0] nomOffset;
  logic [PER_W-1:0] fastOffset;

  canbs_offset #(.PER_W(PER_W), .PCT_W(PCT_W)) uNomOff (
    .periodQ(nomPeriod), .pct(samplePct), .offsetQ(nomOffset));

  canbs_offset #(.PER_W(PER_W), .PCT_W(PCT_W)) uFastOff (
    .periodQ(fastPeriod), .pct(samplePct), .offsetQ(fastOffset));

  canbs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .rateFast(rateFast),
    .frameEnd(frameEnd), .sampleDue(sampleDue), .st(st), .collecting(active));

  canbs_datapath #(.PER_W(PER_W), .FRAC_W(FRAC_W), .TICK_W(TICK_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .collecting(active), .st(st),
    .nomPeriod(nomPeriod), .fastPeriod(fastPeriod),
    .nomOffset(nomOffset), .fastOffset(fastOffset),
    .sampleDue(sampleDue), .bitStrobe(bitStrobe), .bitValue(bitValue),
    .bitCount(bitCount));

endmodule

// File: tb/can_bit_sampler_test.sv
`timescale 1ns/1ps
module can_bit_sampler_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [19:0] nomPeriod = 20'd12800;   // 50 ticks
  logic [19:0] fastPeriod = 20'd6400;   // 25 ticks
  logic [6:0]  samplePct = 7'd70;
  logic        rateFast = 1'b0;
  logic        frameEnd = 1'b0;
  logic        bitStrobe, bitValue, active;
  logic [9:0]  bitCount;

  int total = 0;
  int bad = 0;
  int tickNow = 0;
  int evN = 0;
  int evTick[64];
  int evVal[64];
  int evCnt[64];
  bit finished = 0;

  can_bit_sampler uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .nomPeriod(nomPeriod),
    .fastPeriod(fastPeriod), .samplePct(samplePct), .rateFast(rateFast),
    .frameEnd(frameEnd), .bitStrobe(bitStrobe), .bitValue(bitValue),
    .bitCount(bitCount), .active(active));

  always #10 clk = ~clk;

  always @(posedge clk) tickNow <= tickNow + 1;

  always @(negedge clk) begin
    if (bitStrobe && evN < 64) begin
      evTick[evN] = tickNow;
      evVal[evN]  = int'(bitValue);
      evCnt[evN]  = int'(bitCount);
      evN = evN + 1;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic val, input int n);
    rxLine = val;
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(input int t);
    while (tickNow < t) @(negedge clk);
  endtask

  task automatic endFrame();
    @(negedge clk);
    rxLine = 1'b1;
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    repeat (4) @(negedge clk);
    evN = 0;
  endtask

  task automatic checkEvent(input string req, input int i, input int expTick,
                            input int expVal, input int expCnt);
    checkEq(req, $sformatf("strobe %0d tick", i), evTick[i], expTick);
    checkEq(req, $sformatf("strobe %0d value", i), evVal[i], expVal);
    checkEq(req, $sformatf("strobe %0d index", i), evCnt[i], expCnt);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1", "strobe after reset", int'(bitStrobe), 0);
    checkEq("R1", "count after reset", int'(bitCount), 0);
    checkEq("R1", "active after reset", int'(active), 0);
  endtask

  task automatic testIdle();
    evN = 0;
    drive(1'b1, 200);
    checkEq("R2", "strobes while recessive idle", evN, 0);
    checkEq("R2", "active while recessive idle", int'(active), 0);
  endtask

  task automatic testNominal();
    int a;
    int bits[6] = '{0, 1, 0, 0, 1, 1};
    a = tickNow + 1;
    for (int i = 0; i < 6; i++) drive(bits[i][0], 50);
    drive(1'b1, 20);
    checkEq("R2", "active after low level", int'(active), 1);
    checkEq("R8", "strobes in six bits", evN, 6);
    for (int i = 0; i < 6; i++) checkEvent("R3 R4 R8", i, a + 35 + 50 * i, bits[i], i);
    endFrame();
  endtask

  task automatic testResync();
    int a;
    a = tickNow + 1;
    drive(1'b0, 50);
    drive(1'b1, 80);
    drive(1'b0, 50);
    drive(1'b1, 10);
    checkEvent("R5", 1, a + 85, 1, 1);
    checkEvent("R5", 2, a + 165, 0, 2);
    endFrame();
  endtask

  task automatic testCoincident();
    int a;
    a = tickNow + 1;
    drive(1'b0, 50);
    drive(1'b1, 35);
    drive(1'b0, 100);
    waitUntil(a + 175);
    checkEvent("R6", 1, a + 85, 0, 1);
    checkEvent("R6", 2, a + 170, 0, 2);
    endFrame();
  endtask

  task automatic testFraction();
    int a;
    int expT[5] = '{25, 75, 126, 176, 227};
    nomPeriod = 20'd12928;   // 50.5 ticks
    samplePct = 7'd50;
    repeat (2) @(negedge clk);
    a = tickNow + 1;
    drive(1'b0, 50);
    rxLine = 1'b1;
    waitUntil(a + 240);
    checkEq("R7", "strobes with fractional period", evN, 5);
    for (int i = 0; i < 5; i++)
      checkEq("R7", $sformatf("fractional strobe %0d tick", i), evTick[i], a + expT[i]);
    endFrame();
    nomPeriod = 20'd12800;
    samplePct = 7'd70;
  endtask

  task automatic testRate();
    int a;
    int b;
    a = tickNow + 1;
    drive(1'b0, 50);
    rxLine = 1'b1;
    waitUntil(a + 87);
    rateFast = 1'b1;          // seen at a+88
    waitUntil(a + 157);
    rateFast = 1'b0;          // seen at a+158
    waitUntil(a + 240);
    checkEq("R9", "strobe 2 tick after raise", evTick[2], a + 130);
    checkEq("R9", "strobe 3 tick fast spacing", evTick[3], a + 155);
    checkEq("R10", "pending strobe after lower", evTick[4], a + 180);
    checkEq("R10", "nominal spacing after lower", evTick[5], a + 230);
    checkEq("R8", "index after rate changes", evCnt[5], 5);
    waitUntil(a + 245);
    rateFast = 1'b1;
    repeat (3) @(negedge clk);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    checkEq("R11", "active after frame end", int'(active), 0);
    checkEq("R11", "count after frame end", int'(bitCount), 0);
    evN = 0;
    drive(1'b1, 5);
    checkEq("R11", "no strobes in idle after frame end", evN, 0);
    b = tickNow + 1;
    drive(1'b0, 50);
    rxLine = 1'b1;
    waitUntil(b + 100);
    checkEvent("R11", 0, b + 35, 0, 0);
    checkEvent("R11", 1, b + 85, 1, 1);
    rateFast = 1'b0;
    endFrame();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdle();
    testNominal();
    testResync();
    testCoincident();
    testFraction();
    testRate();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule